// File: doc/BRIEF.md
# Two-Phase Watchdog Timer

This block is a watchdog with two stages of timeout. A base divider turns the system clock into a long tick. A power-of-two prescaler stretches that tick. Two phase counters then count scaled ticks. When the first stage runs out, the block raises a sticky interrupt and moves straight into the second stage. Software must service the watchdog by kicking it before the second stage runs out. If it does not, the block drives one of three reset request lines for a fixed number of clocks. Which line it drives depends on a reset-mode field.

Software starts the timer by raising `enable`. While the first stage is running, software can stop the timer by dropping `enable`. Once the interrupt has fired, the timer can no longer be stopped: only a kick, or the reset that follows, ends the sequence. The prescale, both stage lengths and the reset mode are captured when the timer is started or kicked. Changes made while a stage is running do not disturb that stage.

Top module: `dualstage_watchdog`

## Requirements
- R1: After `rstN` is released, `wdState` is 0 (idle), and `irqOut`, `rstChipReq`, `rstCpuReq` and `rstSoftReq` are all low.
- R2: `wdState` encodes the stages as 0 = idle, 1 = stage 1, 2 = stage 2 and 3 = reset pulse. Suppose the timer is started or kicked at clock edge k. Then stage 1 ends at edge k + (len1+1)·2^ps·BASE_DIV. At that edge `wdState` becomes 2.
- R3: `irqOut` rises at the same edge on which stage 1 ends. It then stays high until `irqClear` is sampled high or a kick is accepted. If the interrupt is set and cleared in the same cycle, the set wins.
- R4: Stage 2 lasts (len2+1)·2^ps·BASE_DIV cycles, measured from the end of stage 1. At its end `wdState` becomes 3.
- R5: In state 3, exactly one reset line is high, for RST_PULSE (16) cycles, and then the block returns to idle. The line is chosen by the reset mode: 0 drives `rstChipReq`, 1 drives `rstCpuReq`, 2 drives `rstSoftReq`, and 3 drives `rstChipReq`. No setting suppresses the reset.
- R6: In stage 1, a low `enable` returns the block to idle, and no interrupt is raised. In stages 2 and 3, `enable` has no effect.
- R7: A kick in stage 1 (with `enable` high) or in stage 2 restarts stage 1 from zero and clears `irqOut`.
- R8: `prescale`, `len1`, `len2` and `rstMode` are captured only when the timer starts or a kick is accepted. Changes to them mid-stage do not alter the running timing.
- R9: The prescale field multiplies the tick period by 2^ps, where ps = 0..3 gives factors of 1, 2, 4 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Starts the timer; may stop it only in stage 1 |
| kick | input | 1 | Service pulse that restarts stage 1 |
| prescale | input | 2 | Tick multiplier exponent |
| len1 | input | 5 | Stage 1 length minus one, in scaled ticks |
| len2 | input | 5 | Stage 2 length minus one, in scaled ticks |
| rstMode | input | 2 | Selects the reset line |
| irqClear | input | 1 | Clears the sticky interrupt |
| irqOut | output | 1 | Stage 1 expiry interrupt |
| rstChipReq | output | 1 | Full chip reset request |
| rstCpuReq | output | 1 | CPU-only reset request |
| rstSoftReq | output | 1 | Software-visible reset request |
| wdState | output | 2 | Current stage |

## Verification
A divider, prescaler or stage counter that is off by one moves the rise of `irqOut` or of a reset line by a multiple of the tick. A bench with a small divider sees this as a cycle count that misses its exact target. A wrongly captured configuration shows up the same way, with the error seen at the first expiry after the bad capture. A broken stop lock-out or kick path shows on `wdState` within one cycle of the stimulus. A wrong mode decode shows on the reset lines as soon as state 3 is entered.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PH1  = 2'd1,
    ST_PH2  = 2'd2,
    ST_RST  = 2'd3
  } wdState_t;

  typedef struct packed {
    logic cfgLoad;
    logic run;
    logic selPh2;
  } wdStrobe_t;
endpackage

// File: rtl/wdog_dpath.sv
module wdog_dpath
  import wdog_pkg::*;
#(
  parameter int BASE_DIV = 33554432,
  parameter int LEN_W    = 5,
  parameter int PS_W     = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdStrobe_t        strobe,
  input  logic [PS_W-1:0]  prescaleIn,
  input  logic [LEN_W-1:0] len1In,
  input  logic [LEN_W-1:0] len2In,
  input  logic [1:0]       modeIn,
  output logic             expire,
  output logic [1:0]       modeQ
);
  localparam int DIV_W = (BASE_DIV > 2) ? $clog2(BASE_DIV) : 1;
  localparam int PRE_W = (1 << PS_W) - 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(BASE_DIV - 1);

  logic [DIV_W-1:0] divCnt;
  logic [PRE_W-1:0] preCnt, preMask;
  logic [LEN_W-1:0] phCnt, len1Q, len2Q, lenSel;
  logic [PS_W-1:0]  psQ;
  logic             tick, unitTick;

  always_comb begin
    preMask = '0;
    for (int i = 0; i < PRE_W; i++) preMask[i] = (i < int'(psQ));
  end

  assign tick     = (divCnt == DIV_LAST);
  assign unitTick = tick && (preCnt == preMask);
  assign lenSel   = strobe.selPh2 ? len2Q : len1Q;
  assign expire   = strobe.run && unitTick && (phCnt == lenSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0; preCnt <= '0; phCnt <= '0;
      len1Q <= '0; len2Q <= '0; psQ <= '0; modeQ <= '0;
    end else if (strobe.cfgLoad) begin
      divCnt <= '0; preCnt <= '0; phCnt <= '0;
      len1Q <= len1In; len2Q <= len2In; psQ <= prescaleIn; modeQ <= modeIn;
    end else if (strobe.run) begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (tick) preCnt <= (preCnt == preMask) ? '0 : preCnt + 1'b1;
      if (unitTick) phCnt <= (phCnt == lenSel) ? '0 : phCnt + 1'b1;
    end else begin
      divCnt <= '0; preCnt <= '0; phCnt <= '0;
    end
  end

  // R2 / R4: stage counter never passes the selected length
  p_phcnt_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.run |-> (phCnt <= lenSel));
  // R9: prescale counter stays within the selected power of two
  p_pre_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.run |-> (preCnt <= preMask));
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int RST_PULSE = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      kick,
  input  logic      irqClear,
  input  logic      expire,
  input  logic [1:0] modeQ,
  output wdStrobe_t strobe,
  output wdState_t  state,
  output logic      irq,
  output logic      rstChipReq,
  output logic      rstCpuReq,
  output logic      rstSoftReq
);
  localparam int PW = (RST_PULSE > 2) ? $clog2(RST_PULSE) : 1;
  localparam logic [PW-1:0] PULSE_LAST = PW'(RST_PULSE - 1);

  wdState_t      nextState;
  logic [PW-1:0] pulseCnt;
  logic          kickAcc, inRst;

  assign kickAcc = kick && (((state == ST_PH1) && enable) || (state == ST_PH2));

  always_comb begin
    nextState      = state;
    strobe.cfgLoad = 1'b0;
    strobe.run     = (state == ST_PH1) || (state == ST_PH2);
    strobe.selPh2  = (state == ST_PH2);
    unique case (state)
      ST_IDLE: if (enable) begin nextState = ST_PH1; strobe.cfgLoad = 1'b1; end
      ST_PH1: begin
        if (!enable)      nextState = ST_IDLE;
        else if (kickAcc) strobe.cfgLoad = 1'b1;
        else if (expire)  nextState = ST_PH2;
      end
      ST_PH2: begin
        if (kickAcc)     begin nextState = ST_PH1; strobe.cfgLoad = 1'b1; end
        else if (expire) nextState = ST_RST;
      end
      ST_RST: if (pulseCnt == PULSE_LAST) nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; pulseCnt <= '0; irq <= 1'b0;
    end else begin
      state    <= nextState;
      pulseCnt <= (state == ST_RST) ? pulseCnt + 1'b1 : '0;
      if (kickAcc) irq <= 1'b0;
      else if ((state == ST_PH1) && enable && expire) irq <= 1'b1;
      else if (irqClear) irq <= 1'b0;
    end
  end

  assign inRst      = (state == ST_RST);
  assign rstChipReq = inRst && ((modeQ == 2'd0) || (modeQ == 2'd3));
  assign rstCpuReq  = inRst && (modeQ == 2'd1);
  assign rstSoftReq = inRst && (modeQ == 2'd2);

  // R5: never more than one reset line
  p_onehot_rst_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rstChipReq, rstCpuReq, rstSoftReq}));
  // R5: reset pulse only entered from stage 2
  p_rst_from_ph2_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_RST) && ($past(state) != ST_RST)) |-> ($past(state) == ST_PH2));
  // R6: stage 2 cannot be left without a kick or expiry
  p_no_stop_ph2_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_PH2) && !kick && !expire) |=> (state == ST_PH2));
  // R3: interrupt is sticky
  p_irq_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !irqClear && !kick) |=> irq);
  // R7: accepted kick restarts stage 1 and clears the interrupt
  p_kick_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    (kick && (((state == ST_PH1) && enable) || (state == ST_PH2))) |=> ((state == ST_PH1) && !irq));
endmodule

// File: rtl/dualstage_watchdog.sv
module dualstage_watchdog
  import wdog_pkg::*;
#(
  parameter int BASE_DIV  = 33554432,
  parameter int RST_PULSE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       kick,
  input  logic [1:0] prescale,
  input  logic [4:0] len1,
  input  logic [4:0] len2,
  input  logic [1:0] rstMode,
  input  logic       irqClear,
  output logic       irqOut,
  output logic       rstChipReq,
  output logic       rstCpuReq,
  output logic       rstSoftReq,
  output logic [1:0] wdState
);
  wdStrobe_t  strobe;
  wdState_t   state;
  logic       expire;
  logic [1:0] modeQ;

  wdog_dpath #(.BASE_DIV(BASE_DIV), .LEN_W(5), .PS_W(2)) i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .prescaleIn(prescale),
    .len1In(len1), .len2In(len2), .modeIn(rstMode),
    .expire(expire), .modeQ(modeQ)
  );

  wdog_ctrl #(.RST_PULSE(RST_PULSE)) i_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .kick(kick), .irqClear(irqClear),
    .expire(expire), .modeQ(modeQ), .strobe(strobe), .state(state), .irq(irqOut),
    .rstChipReq(rstChipReq), .rstCpuReq(rstCpuReq), .rstSoftReq(rstSoftReq)
  );

  assign wdState = state;
endmodule

// File: tb/test_dualstage_watchdog.sv
module test_dualstage_watchdog;
  localparam int DIV = 4;
  localparam int NVEC = 6;
  // {ps, len1, len2, mode}
  localparam logic [13:0] VEC [NVEC] = '{
    {2'd0, 5'd0, 5'd0, 2'd0}, {2'd1, 5'd2, 5'd1, 2'd1}, {2'd2, 5'd1, 5'd3, 2'd2},
    {2'd3, 5'd0, 5'd0, 2'd3}, {2'd0, 5'd5, 5'd2, 2'd1}, {2'd3, 5'd3, 5'd1, 2'd0}};

  logic clk = 0, rstN = 0, enable = 0, kick = 0, irqClear = 0;
  logic [1:0] prescale = 0, rstMode = 0;
  logic [4:0] len1 = 0, len2 = 0;
  logic irqOut, rstChipReq, rstCpuReq, rstSoftReq;
  logic [1:0] wdState;
  int nTests = 0, nFail = 0, cyc = 0;

  always #4 clk = ~clk;

  dualstage_watchdog #(.BASE_DIV(DIV), .RST_PULSE(16)) i_dualstage_watchdog (
    .clk(clk), .rstN(rstN), .enable(enable), .kick(kick), .prescale(prescale),
    .len1(len1), .len2(len2), .rstMode(rstMode), .irqClear(irqClear),
    .irqOut(irqOut), .rstChipReq(rstChipReq), .rstCpuReq(rstCpuReq),
    .rstSoftReq(rstSoftReq), .wdState(wdState));

  task automatic check(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic countUntil(input int sel, output int n);
    n = 0;
    do begin @(negedge clk); n++; end
    while (!((sel == 0) ? irqOut : (rstChipReq | rstCpuReq | rstSoftReq)) && n < 5000);
  endtask

  function automatic int expLine(input logic [1:0] m);
    return (m == 2'd1) ? 2 : (m == 2'd2) ? 4 : 1;
  endfunction

  task automatic fullRun(input logic [13:0] v);
    int n, w, t1, t2;
    t1 = (v[11:7] + 1) * (1 << v[13:12]) * DIV;
    t2 = (v[6:2] + 1) * (1 << v[13:12]) * DIV;
    @(negedge clk);
    {prescale, len1, len2, rstMode} = v; enable = 1;
    countUntil(0, n);
    check("R2/R9 stage1 length", n - 1, t1);
    check("R2 state after stage1", wdState, 2);
    enable = 0; // R6: ignored in stage 2
    countUntil(1, n);
    check("R4 stage2 length", n, t2);
    check("R5 reset line", {rstSoftReq, rstCpuReq, rstChipReq}, expLine(v[1:0]));
    w = 0;
    while ((rstChipReq | rstCpuReq | rstSoftReq) && w < 100) begin @(negedge clk); w++; end
    check("R5 pulse width", w, 16);
    check("R5 back to idle", wdState, 0);
    irqClear = 1; @(negedge clk); irqClear = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        nTests++; nFail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
        $finish;
      end
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 state", wdState, 0);
    check("R1 outputs", {irqOut, rstChipReq, rstCpuReq, rstSoftReq}, 0);
    rstN = 1;
    @(negedge clk);
    check("R1 state after release", wdState, 0);

    for (int i = 0; i < NVEC; i++) fullRun(VEC[i]);

    // R6: disable in stage 1 stops the timer
    {prescale, len1, len2, rstMode} = {2'd0, 5'd3, 5'd0, 2'd0}; enable = 1;
    repeat (5) @(negedge clk);
    check("R6 running", wdState, 1);
    enable = 0; @(negedge clk);
    check("R6 stopped", wdState, 0);
    repeat (40) @(negedge clk);
    check("R6 no irq", irqOut, 0);

    // R8: config change mid-stage ignored; R7 kick; R3 clear
    {prescale, len1, len2, rstMode} = {2'd0, 5'd1, 5'd7, 2'd0}; enable = 1;
    @(negedge clk);
    len1 = 5'd9;
    countUntil(0, n);
    check("R8 captured len1", n, 8);
    repeat (5) @(negedge clk);
    check("R3 sticky", irqOut, 1);
    irqClear = 1; @(negedge clk); irqClear = 0;
    check("R3 cleared", irqOut, 0);
    check("R3 clear keeps stage2", wdState, 2);
    len1 = 5'd1;
    kick = 1; @(negedge clk); kick = 0;
    check("R7 kick to stage1", wdState, 1);
    countUntil(0, n);
    check("R7 restart timing", n, 8);
    kick = 1; @(negedge clk); kick = 0;
    check("R7 irq cleared by kick", irqOut, 0);
    check("R7 state", wdState, 1);
    enable = 0; @(negedge clk);
    check("R6 stop after kick", wdState, 0);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule